// File: doc/BRIEF.md
# Program Counter Sequencer for a Single-Cycle Core

This block keeps the program counter of a single-cycle processor and picks the address of the following instruction on every clock edge. The PC goes straight to the address input of an instruction memory that reads combinationally. The 32-bit word that comes back is split into its fields and handed on to the decoder and the register file.

Each cycle the block chooses one of three next addresses:

- The sequential address, PC + 4.
- A relative branch target, PC + 4 plus the instruction's 16-bit immediate, sign-extended and scaled by four.
- An absolute jump target, formed from the top four bits of PC + 4, the 26-bit target field and two zero bits.

Control does not drive the branch choice directly. It supplies a branch/not-branch bit, and the block combines that bit with the ALU's zero flag. A jump request overrides the branch path.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset loads the PC with RESET_ADDR (default 0) on the next rising clock edge, and that value appears on `pcAddr`.
- R2: With `branchSel` = 0 and `jumpEn` = 0, the PC advances by 4 on each rising edge, whatever the value of `aluZero`.
- R3: With `branchSel` = 1, `aluZero` = 1 and `jumpEn` = 0, the next PC is PC + 4 + (sign-extended `instrWord[15:0]` shifted left by 2). Negative offsets therefore move the PC backwards.
- R4: With `branchSel` = 1, `aluZero` = 0 and `jumpEn` = 0, the branch is not taken and the next PC is PC + 4.
- R5: With `jumpEn` = 1, the next PC is {(PC + 4)[31:28], `instrWord[25:0]`, 2'b00}.
- R6: `jumpEn` = 1 overrides a taken branch (`branchSel` = 1 and `aluZero` = 1). The jump target of R5 is still used.
- R7: The field outputs follow the current instruction word combinationally:
  - `opField` = bits 31:26
  - `rsField` = bits 25:21
  - `rtField` = bits 20:16
  - `rdField` = bits 15:11
  - `immField` = bits 15:0
- R8: All PC arithmetic wraps modulo 2^32, so 0xFFFFFFFC followed by a sequential step gives 0.
- R9: Once reset has been applied, the two low bits of `pcAddr` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| branchSel | input | 1 | Branch/not-branch control from the main decoder |
| aluZero | input | 1 | Zero flag from the ALU compare |
| jumpEn | input | 1 | Absolute jump request |
| instrWord | input | 32 | Instruction word returned by the instruction memory |
| pcAddr | output | ADDR_W (32) | Current PC, driven to the instruction memory address |
| opField | output | 6 | Opcode field |
| rsField | output | 5 | First source register number |
| rtField | output | 5 | Second source / immediate destination register number |
| rdField | output | 5 | Register-format destination number |
| immField | output | 16 | 16-bit immediate |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a reset address of zero. The full 32-bit width matters for the checks: a far negative branch takes the PC into the top of the address space, and the upper-bits jump then reaches 0xFFFFFFFC and exposes the wrap to zero. A sweep visits every 16-bit immediate value once. On each step it rotates through all eight combinations of branch-select, zero and jump, so the sign extension, the AND of branch-select with zero, and the priority of jump over a taken branch are all exercised across the whole immediate range.

// File: rtl/pc_seq_pkg.sv
`timescale 1ns/1ps
package pc_seq_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 16;
  localparam int TGT_W   = 26;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int STEP    = 4;

  // strobes from the next-address control to the datapath
  typedef struct packed {
    logic useBranch;
    logic useJump;
  } pcStrobes_t;
endpackage

// File: rtl/pc_seq_ctrl.sv
`timescale 1ns/1ps
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic       branchSel,
  input  logic       aluZero,
  input  logic       jumpEn,
  output pcStrobes_t strobes
);
  always_comb begin
    strobes.useJump   = jumpEn;
    // branch only when control asks for it and the compare was equal
    strobes.useBranch = branchSel & aluZero & ~jumpEn;
  end
endmodule

// File: rtl/pc_seq_fields.sv
`timescale 1ns/1ps
module pc_seq_fields
  import pc_seq_pkg::*;
(
  input  logic [INSTR_W-1:0] instrWord,
  output logic [OP_W-1:0]    opField,
  output logic [REG_W-1:0]   rsField,
  output logic [REG_W-1:0]   rtField,
  output logic [REG_W-1:0]   rdField,
  output logic [IMM_W-1:0]   immField,
  output logic [TGT_W-1:0]   tgtField
);
  localparam int OP_LO = INSTR_W - OP_W;
  localparam int RS_LO = OP_LO - REG_W;
  localparam int RT_LO = RS_LO - REG_W;
  localparam int RD_LO = RT_LO - REG_W;

  always_comb begin
    opField  = instrWord[INSTR_W-1:OP_LO];
    rsField  = instrWord[OP_LO-1:RS_LO];
    rtField  = instrWord[RS_LO-1:RT_LO];
    rdField  = instrWord[RT_LO-1:RD_LO];
    immField = instrWord[IMM_W-1:0];
    tgtField = instrWord[TGT_W-1:0];
  end
endmodule

// File: rtl/pc_seq_dp.sv
`timescale 1ns/1ps
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobes_t        strobes,
  input  logic [IMM_W-1:0]  immField,
  input  logic [TGT_W-1:0]  tgtField,
  output logic [ADDR_W-1:0] pcAddr
);
  localparam int SEXT_W = ADDR_W - IMM_W - 2;
  localparam int HI_W   = ADDR_W - TGT_W - 2;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] branchOfs;
  logic [ADDR_W-1:0] branchTgt;
  logic [ADDR_W-1:0] jumpTgt;
  logic [ADDR_W-1:0] nextPc;

  always_comb begin
    pcPlus4   = pcReg + ADDR_W'(STEP);
    branchOfs = {{SEXT_W{immField[IMM_W-1]}}, immField, 2'b00};
    branchTgt = pcPlus4 + branchOfs;
    jumpTgt   = {pcPlus4[ADDR_W-1 -: HI_W], tgtField, 2'b00};
  end

  // jump wins over branch, branch over sequential
  always_comb begin
    if (strobes.useJump)        nextPc = jumpTgt;
    else if (strobes.useBranch) nextPc = branchTgt;
    else                        nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcReg <= RESET_ADDR;
    else     pcReg <= nextPc;
  end

  assign pcAddr = pcReg;
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branchSel,
  input  logic              aluZero,
  input  logic              jumpEn,
  input  logic [31:0]       instrWord,
  output logic [ADDR_W-1:0] pcAddr,
  output logic [5:0]        opField,
  output logic [4:0]        rsField,
  output logic [4:0]        rtField,
  output logic [4:0]        rdField,
  output logic [15:0]       immField
);
  pcStrobes_t       strobes;
  logic [TGT_W-1:0] tgtField;

  pc_seq_ctrl u_ctrl (
    .branchSel (branchSel),
    .aluZero   (aluZero),
    .jumpEn    (jumpEn),
    .strobes   (strobes)
  );

  pc_seq_fields u_fields (
    .instrWord (instrWord),
    .opField   (opField),
    .rsField   (rsField),
    .rtField   (rtField),
    .rdField   (rdField),
    .immField  (immField),
    .tgtField  (tgtField)
  );

  pc_seq_dp #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .immField (immField),
    .tgtField (tgtField),
    .pcAddr   (pcAddr)
  );
endmodule

// File: rtl/pc_sequencer_chk.sv
`timescale 1ns/1ps
module pc_sequencer_chk #(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              branchSel,
  input logic              aluZero,
  input logic              jumpEn,
  input logic [31:0]       instrWord,
  input logic [ADDR_W-1:0] pcAddr
);
  logic pastRst  = 1'b0;
  logic pastSeen = 1'b0;

  always_ff @(posedge clk) begin
    pastRst  <= rst;
    pastSeen <= 1'b1;
  end

  // R1: one edge after reset was sampled, the PC holds the reset address
  always @(posedge clk) begin
    if (pastSeen && pastRst)
      assert_reset_addr_R1: assert (pcAddr == RESET_ADDR);
  end

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!branchSel && !jumpEn) |=> pcAddr == $past(pcAddr) + ADDR_W'(4));

  assert_branch_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (branchSel && aluZero && !jumpEn) |=>
      pcAddr == $past(pcAddr) + ADDR_W'(4) +
        {{(ADDR_W-18){$past(instrWord[15])}}, $past(instrWord[15:0]), 2'b00});

  assert_branch_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (branchSel && !aluZero && !jumpEn) |=> pcAddr == $past(pcAddr) + ADDR_W'(4));

  // R5 and R6: jump target regardless of the branch inputs
  assert_jump_target_R5: assert property (@(posedge clk) disable iff (rst)
    jumpEn |=> pcAddr[ADDR_W-5:0] == {$past(instrWord[25:0]), 2'b00});

  assert_word_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    pastSeen |-> pcAddr[1:0] == 2'b00);
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .branchSel (branchSel),
  .aluZero   (aluZero),
  .jumpEn    (jumpEn),
  .instrWord (instrWord),
  .pcAddr    (pcAddr)
);

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branchSel = 1'b0;
  logic        aluZero = 1'b0;
  logic        jumpEn = 1'b0;
  logic [31:0] instrWord;
  logic [31:0] pcAddr;
  logic [5:0]  opField;
  logic [4:0]  rsField, rtField, rdField;
  logic [15:0] immField;

  logic [31:0] imem [64];
  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  assign instrWord = imem[pcAddr[7:2]];

  pc_sequencer dut (
    .clk(clk), .rst(rst), .branchSel(branchSel), .aluZero(aluZero),
    .jumpEn(jumpEn), .instrWord(instrWord), .pcAddr(pcAddr),
    .opField(opField), .rsField(rsField), .rtField(rtField),
    .rdField(rdField), .immField(immField)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference next address, written from the requirements
  function automatic logic [31:0] refNext(logic [31:0] pc, logic bs, logic z,
                                          logic j, logic [31:0] w);
    logic [31:0] seq;
    logic signed [31:0] ofs;
    seq = pc + 32'd4;
    ofs = 32'(signed'(w[15:0])) * 4;
    if (j)            return {seq[31:28], w[25:0], 2'b00};
    else if (bs && z) return seq + 32'(ofs);
    else              return seq;
  endfunction

  // called at a falling edge: load word at current PC, apply controls, clock once
  task automatic step(input logic bs, input logic z, input logic j,
                      input logic [31:0] w, input string req, input bit chkFields);
    logic [31:0] exp;
    imem[pcAddr[7:2]] = w;
    branchSel = bs; aluZero = z; jumpEn = j;
    #1;
    if (chkFields) begin
      check("R7 op", {26'd0, opField}, {26'd0, w[31:26]});
      check("R7 rs", {27'd0, rsField}, {27'd0, w[25:21]});
      check("R7 rt", {27'd0, rtField}, {27'd0, w[20:16]});
      check("R7 rd", {27'd0, rdField}, {27'd0, w[15:11]});
      check("R7 imm", {16'd0, immField}, {16'd0, w[15:0]});
    end
    exp = refNext(pcAddr, bs, z, j, w);
    @(posedge clk);
    @(negedge clk);
    check(req, pcAddr, exp);
  endtask

  initial begin
    #1_500_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] pcBefore;
    for (int k = 0; k < 64; k++) imem[k] = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset value", pcAddr, 32'h0);

    // R2 sequential flow, zero flag toggled without effect
    step(1'b0, 1'b0, 1'b0, 32'h0043_2820, "R2 seq", 1'b1);
    step(1'b0, 1'b1, 1'b0, 32'h1234_FFFF, "R2 seq zero ignored", 1'b1);
    step(1'b0, 1'b0, 1'b0, 32'hAC22_0008, "R2 seq", 1'b1);
    check("R2 pc after three steps", pcAddr, 32'hC);

    // R3 taken backwards branch: offset -8 gives pc - 4
    pcBefore = pcAddr;
    step(1'b1, 1'b1, 1'b0, 32'h1022_FFFE, "R3 negative offset", 1'b1);
    check("R3 backwards target", pcAddr, pcBefore - 32'd4);
    step(1'b1, 1'b1, 1'b0, 32'h1022_0003, "R3 positive offset", 1'b0);

    // R4 not-taken branch
    pcBefore = pcAddr;
    step(1'b1, 1'b0, 1'b0, 32'h1022_7FFF, "R4 not taken", 1'b0);
    check("R4 stays sequential", pcAddr, pcBefore + 32'd4);

    // R5 jump, R6 jump over taken branch
    step(1'b0, 1'b0, 1'b1, 32'h0800_0040, "R5 jump", 1'b1);
    check("R5 jump absolute", pcAddr, 32'h0000_0100);
    step(1'b1, 1'b1, 1'b1, 32'h0800_0010, "R6 jump priority", 1'b0);
    check("R6 jump wins", pcAddr, 32'h0000_0040);

    // R8 wrap: far back branch, then top jump, then sequential
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R1 reset mid-run", pcAddr, 32'h0);
    step(1'b1, 1'b1, 1'b0, 32'h1000_8000, "R3 most negative offset", 1'b0);
    check("R3 far back", pcAddr, 32'hFFFE_0004);
    step(1'b0, 1'b0, 1'b1, 32'h0BFF_FFFF, "R5 jump top", 1'b0);
    check("R5 top of space", pcAddr, 32'hFFFF_FFFC);
    step(1'b0, 1'b0, 1'b0, 32'h0, "R8 wrap", 1'b0);
    check("R8 wrapped to zero", pcAddr, 32'h0);

    // sweep: every immediate, all eight control combinations rotated
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 65536; i++) begin
      logic [2:0] c;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      c = 3'(i) ^ 3'(i >> 7);
      step(c[0], c[1], c[2], {lfsr[31:16], 16'(i)}, "R2/R3/R4/R5/R6 sweep", (i % 64) == 0);
      if (pcAddr[1:0] != 2'b00) check("R9 alignment", {30'd0, pcAddr[1:0]}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule